// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block takes over the memory bus of an 8-bit-data, 32-bit-address processor core for four kinds of control transfer. These are the reset sequence, a software break, a maskable interrupt and the return from an interrupt.

**Entry (break or interrupt).** The block writes the return address to the stack, one byte per cycle and high byte first. It then writes the status byte. Next it reads a 4-byte little-endian vector from the top of the address space.

**Return.** The block reads the status byte back from the stack, then the four return-address bytes.

**Completion.** In every case the block ends with a one-cycle completion pulse. That pulse presents the new program counter, status byte and stack pointer to the fetch stage. In the same cycle the bus already shows an opcode read at the new program counter.

The core raises a request while its instruction boundary flag is high. The block samples the current program counter, status byte and 8-bit stack pointer at that moment. Memory is byte-wide and reads asynchronously: `din` must carry the byte at `addr` within the same cycle. While the block is idle, the bus shows `pc_in` as a plain read.

Top module: `exc_seq`

## Requirements
- R1: While `rst_n` is low, `busy`, `done` and `we` are all 0.
- R2: Every stack access goes to address 0x100 plus the 8-bit stack pointer. On entry the block makes exactly five consecutive writes. The stack pointer drops by one after each write, wrapping within the page. The returned `sp_out` is `sp_in - 5` modulo 256.
- R3: The return-address bytes are written high byte first, followed by the status byte. A break writes `pc_in + 2` and a status with bit 4 and bit 5 set. An interrupt writes `pc_in` unchanged and a status with bit 4 clear and bit 5 set.
- R4: After the pushes, or straight away for a reset request, the block makes four reads with `we` low. They go to ascending addresses starting at 0xFFFFFFF8 for reset, or at 0xFFFFFFFC for break and interrupt. The bytes are assembled least significant first.
- R5: `done` is high for exactly one cycle per sequence. In that cycle `pc_out` holds the new program counter, and the bus shows a read (`we` low) at that address. For an entry, `status_out` is the pushed status with bit 2 (interrupt disable) set.
- R6: A return first reads 0x100+`sp_in` as a dummy access. It then reads status from the next stack address and the four address bytes from the four addresses after it, least significant first. It finishes with `pc_out` equal to the popped address, `status_out` equal to the popped status, and `sp_out` = `sp_in + 5`.
- R7: A pulse on `irq` is held pending. It is taken only at a boundary while bit 2 of `status_in` is clear. It stays pending while that bit is set.
- R8: When several requests are present in the same accepting cycle, the priority is reset request, then a takeable interrupt, then break, then return. A break that loses to an interrupt is dropped, not queued.
- R9: A reset request aborts any sequence in progress, goes straight to the reset vector reads and discards a pending interrupt.
- R10: While `rdy` is low, `we` is low, the address is held and the sequence does not advance. Once `rdy` returns, the sequence completes with the same bytes.
- R11: A reset sequence performs no stack writes, returns `sp_out` = `sp_in`, and sets bit 2 in `status_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy | input | 1 | Bus ready; low stalls every bus cycle |
| boundary | input | 1 | Core is between instructions; break, return and interrupt may start |
| reset_req | input | 1 | Start the reset sequence (accepted in any state) |
| irq | input | 1 | Maskable interrupt request pulse |
| brk_req | input | 1 | Start a break entry |
| rti_req | input | 1 | Start a return from interrupt |
| pc_in | input | 32 | Current program counter |
| status_in | input | 8 | Current status byte (bit 2 interrupt disable) |
| sp_in | input | 8 | Current stack pointer |
| din | input | 8 | Read data for `addr`, same cycle |
| addr | output | 32 | Bus address |
| we | output | 1 | Bus write enable |
| dout | output | 8 | Bus write data |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 32 | New program counter, valid with `done` |
| status_out | output | 8 | New status byte, valid with `done` |
| sp_out | output | 8 | New stack pointer, valid with `done` |

## Verification
The case of interest is a pending interrupt and a break request reaching the same accepting cycle. The bench sets the interrupt-disable bit, pulses `irq` so that it is latched but not taken, and then clears the bit in the same cycle that `brk_req` is raised. The outcome is judged from the stack bytes. The pushed address must be `pc_in` without the +2, the pushed status must have bit 4 clear, and no second sequence may follow. A second overlap is a reset request arriving in the middle of a break push. It must redirect the block to the reset vector and leave no interrupt pending.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_VEC,
    ST_DUMMY,
    ST_POP,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    KIND_RESET,
    KIND_IRQ,
    KIND_BRK,
    KIND_RTI
  } seq_kind_e;

  // status byte bit positions used by the sequencer
  localparam int FLAG_IDIS = 2;
  localparam int FLAG_BRK  = 4;
  localparam int FLAG_ONE  = 5;

endpackage

// File: rtl/exc_sp_unit.sv
module exc_sp_unit #(
  parameter int                SP_W   = 8,
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic [SP_W-1:0]   load_val,
  input  logic              step_dn,
  input  logic              step_up,
  output logic [SP_W-1:0]   sp,
  output logic [ADDR_W-1:0] stk_addr
);

  logic [SP_W-1:0] sp_q, sp_n;

  always_comb begin
    sp_n = sp_q;
    if (load)         sp_n = load_val;
    else if (step_dn) sp_n = sp_q - 1'b1;
    else if (step_up) sp_n = sp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sp_q <= '0;
    else if (en) sp_q <= sp_n;
  end

  assign sp       = sp_q;
  assign stk_addr = BASE + ADDR_W'(sp_q);

endmodule

// File: rtl/exc_irq_latch.sv
module exc_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic take,
  input  logic clear,
  output logic pend
);

  logic pend_q, pend_n;

  always_comb begin
    pend_n = pend_q;
    if (take || clear) pend_n = 1'b0;
    else if (irq)      pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_n;
  end

  assign pend = pend_q;

endmodule

// File: rtl/exc_word_reg.sv
module exc_word_reg #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  localparam int NB    = ADDR_W / DATA_W,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              cap,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] byte_in,
  output logic [ADDR_W-1:0] word
);

  logic [NB-1:0][DATA_W-1:0] lane_q;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [DATA_W-1:0] lane_n;

    always_comb begin
      lane_n = lane_q[g];
      if (load)                            lane_n = load_val[g*DATA_W +: DATA_W];
      else if (cap && idx == IDX_W'(g))    lane_n = byte_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lane_q[g] <= '0;
      else if (en) lane_q[g] <= lane_n;
    end
  end

  assign word = lane_q;

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 8,
  parameter int                SP_W       = 8,
  parameter logic [ADDR_W-1:0] STACK_BASE = 'h100,
  parameter logic [ADDR_W-1:0] VEC_RESET  = 'hFFFF_FFF8,
  parameter logic [ADDR_W-1:0] VEC_IRQ    = 'hFFFF_FFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy,
  input  logic              boundary,
  input  logic              reset_req,
  input  logic              irq,
  input  logic              brk_req,
  input  logic              rti_req,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] status_in,
  input  logic [SP_W-1:0]   sp_in,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] addr,
  output logic              we,
  output logic [DATA_W-1:0] dout,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] status_out,
  output logic [SP_W-1:0]   sp_out
);

  localparam int NB    = ADDR_W / DATA_W;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int CNT_W = $clog2(NB + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(NB);
  localparam logic [CNT_W-1:0]  CNT_TOP  = CNT_W'(NB - 1);
  localparam logic [DATA_W-1:0] M_IDIS   = DATA_W'(1) << FLAG_IDIS;
  localparam logic [DATA_W-1:0] M_BRK    = DATA_W'(1) << FLAG_BRK;
  localparam logic [DATA_W-1:0] M_ONE    = DATA_W'(1) << FLAG_ONE;

  seq_state_e        state_q, state_n;
  seq_kind_e         kind_q, kind_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] stat_q, stat_n;

  logic              sp_load, sp_dn, sp_up;
  logic [SP_W-1:0]   sp_cur;
  logic [ADDR_W-1:0] stk_addr;

  logic              w_load, w_cap;
  logic [ADDR_W-1:0] w_val, word_q;
  logic [IDX_W-1:0]  w_idx;

  logic              irq_pend, irq_take, irq_clr;
  logic              irq_ok, at_idle, adv;
  logic              start_rst, start_irq, start_brk, start_rti;
  logic [ADDR_W-1:0] vec_base;
  logic [DATA_W-1:0] push_byte;

  // ---------------- sub-units ----------------
  exc_sp_unit #(
    .SP_W   (SP_W),
    .ADDR_W (ADDR_W),
    .BASE   (STACK_BASE)
  ) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rdy),
    .load     (sp_load),
    .load_val (sp_in),
    .step_dn  (sp_dn),
    .step_up  (sp_up),
    .sp       (sp_cur),
    .stk_addr (stk_addr)
  );

  exc_irq_latch u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .irq   (irq),
    .take  (irq_take),
    .clear (irq_clr),
    .pend  (irq_pend)
  );

  exc_word_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rdy),
    .load     (w_load),
    .load_val (w_val),
    .cap      (w_cap),
    .idx      (w_idx),
    .byte_in  (din),
    .word     (word_q)
  );

  // ---------------- request arbitration ----------------
  assign at_idle   = (state_q == ST_IDLE) && boundary && rdy && !reset_req;
  assign irq_ok    = irq_pend && !status_in[FLAG_IDIS];
  assign start_rst = rdy && reset_req;
  assign start_irq = at_idle && irq_ok;
  assign start_brk = at_idle && !irq_ok && brk_req;
  assign start_rti = at_idle && !irq_ok && !brk_req && rti_req;

  assign vec_base  = (kind_q == KIND_RESET) ? VEC_RESET : VEC_IRQ;
  assign push_byte = word_q[ADDR_W-1-DATA_W*int'(cnt_q[IDX_W-1:0]) -: DATA_W];

  // ---------------- next-state logic ----------------
  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    kind_n   = kind_q;
    stat_n   = stat_q;
    sp_load  = 1'b0;
    sp_dn    = 1'b0;
    sp_up    = 1'b0;
    w_load   = 1'b0;
    w_val    = pc_in;
    w_cap    = 1'b0;
    w_idx    = cnt_q[IDX_W-1:0];
    irq_take = 1'b0;
    irq_clr  = 1'b0;

    case (state_q)
      ST_PUSH: if (rdy) begin
        sp_dn = 1'b1;
        if (cnt_q == CNT_LAST) begin
          state_n = ST_VEC;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_VEC: if (rdy) begin
        w_cap = 1'b1;
        if (cnt_q == CNT_TOP) state_n = ST_DONE;
        else                  cnt_n   = cnt_q + 1'b1;
      end
      ST_DUMMY: if (rdy) begin
        sp_up   = 1'b1;
        state_n = ST_POP;
        cnt_n   = '0;
      end
      ST_POP: if (rdy) begin
        if (cnt_q == '0) begin
          stat_n = din;
        end else begin
          w_cap = 1'b1;
          w_idx = IDX_W'(cnt_q - 1'b1);
        end
        if (cnt_q == CNT_LAST) begin
          state_n = ST_DONE;
        end else begin
          sp_up = 1'b1;
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_DONE: state_n = ST_IDLE;
      default: ;
    endcase

    if (start_rst) begin
      state_n = ST_VEC;
      cnt_n   = '0;
      kind_n  = KIND_RESET;
      stat_n  = status_in | M_IDIS;
      sp_load = 1'b1;
      irq_clr = 1'b1;
    end else if (start_irq) begin
      state_n  = ST_PUSH;
      cnt_n    = '0;
      kind_n   = KIND_IRQ;
      stat_n   = (status_in & ~M_BRK) | M_ONE;
      sp_load  = 1'b1;
      w_load   = 1'b1;
      w_val    = pc_in;
      irq_take = 1'b1;
    end else if (start_brk) begin
      state_n = ST_PUSH;
      cnt_n   = '0;
      kind_n  = KIND_BRK;
      stat_n  = status_in | M_BRK | M_ONE;
      sp_load = 1'b1;
      w_load  = 1'b1;
      w_val   = pc_in + ADDR_W'(2);
    end else if (start_rti) begin
      state_n = ST_DUMMY;
      cnt_n   = '0;
      kind_n  = KIND_RTI;
      sp_load = 1'b1;
    end
  end

  // ---------------- state registers ----------------
  assign adv = rdy || (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_RESET;
      cnt_q   <= '0;
      stat_q  <= '0;
    end else if (adv) begin
      state_q <= state_n;
      kind_q  <= kind_n;
      cnt_q   <= cnt_n;
      stat_q  <= stat_n;
    end
  end

  // ---------------- bus drive ----------------
  always_comb begin
    addr = pc_in;
    we   = 1'b0;
    dout = '0;
    case (state_q)
      ST_PUSH: begin
        addr = stk_addr;
        we   = rdy;
        dout = (cnt_q == CNT_LAST) ? stat_q : push_byte;
      end
      ST_VEC:          addr = vec_base + ADDR_W'(cnt_q);
      ST_DUMMY, ST_POP: addr = stk_addr;
      ST_DONE:         addr = word_q;
      default: ;
    endcase
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign pc_out     = word_q;
  assign sp_out     = sp_cur;
  assign status_out = (kind_q == KIND_RTI) ? stat_q : (stat_q | M_IDIS);

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int                ADDR_W     = 32,
  parameter int                SP_W       = 8,
  parameter logic [ADDR_W-1:0] STACK_BASE = 'h100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdy,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] pc_out
);

  // R2
  stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ((addr >> SP_W) == (STACK_BASE >> SP_W)));

  // R2
  push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && $past(we)) |-> (addr[SP_W-1:0] == SP_W'($past(addr[SP_W-1:0]) - 1'b1)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!we && addr == pc_out));

  // R10
  stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> !we);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !rdy) |=> $stable(addr));

endmodule

bind exc_seq exc_seq_chk #(
  .ADDR_W     (ADDR_W),
  .SP_W       (SP_W),
  .STACK_BASE (STACK_BASE)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rdy    (rdy),
  .we     (we),
  .addr   (addr),
  .busy   (busy),
  .done   (done),
  .pc_out (pc_out)
);

// File: tb/exc_seq_tb.sv
module exc_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n, rdy, boundary, reset_req, irq, brk_req, rti_req;
  logic [31:0] pc_in;
  logic [7:0]  status_in, sp_in, din;
  logic [31:0] addr;
  logic        we;
  logic [7:0]  dout;
  logic        busy, done;
  logic [31:0] pc_out;
  logic [7:0]  status_out, sp_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit fin    = 1'b0;

  logic [7:0]  stk    [0:255];
  logic [7:0]  vecmem [0:11];
  logic [31:0] t_addr [0:63];
  logic        t_we   [0:63];
  logic [7:0]  t_dout [0:63];
  int          t_n;
  int          d_cnt;
  logic [31:0] d_pc;
  logic [7:0]  d_st, d_sp;

  always #4 clk = ~clk;

  exc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .boundary(boundary),
    .reset_req(reset_req), .irq(irq), .brk_req(brk_req), .rti_req(rti_req),
    .pc_in(pc_in), .status_in(status_in), .sp_in(sp_in), .din(din),
    .addr(addr), .we(we), .dout(dout), .busy(busy), .done(done),
    .pc_out(pc_out), .status_out(status_out), .sp_out(sp_out)
  );

  // asynchronous-read byte memory: stack page and vector area
  assign din = (addr[31:8] == 24'h000001) ? stk[addr[7:0]] :
               (addr >= 32'hFFFF_FFF4)    ? vecmem[4'(addr[3:0] - 4'h4)] : 8'h00;

  always @(posedge clk) if (we && addr[31:8] == 24'h000001) stk[addr[7:0]] <= dout;

  always @(negedge clk) begin
    if (busy && t_n < 64) begin
      t_addr[t_n] = addr;
      t_we[t_n]   = we;
      t_dout[t_n] = dout;
      t_n         = t_n + 1;
    end
    if (done) begin
      d_cnt = d_cnt + 1;
      d_pc  = pc_out;
      d_st  = status_out;
      d_sp  = sp_out;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_trace();
    t_n = 0;
    d_cnt = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200 && d_cnt == 0; i++) begin
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
  endtask

  task automatic wait_trace(input int n);
    for (int i = 0; i < 200 && t_n != n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic chk_push(input string req, input int base, input logic [7:0] sp0,
                          input logic [31:0] pc, input logic [7:0] st);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] e;
      e = (k < 4) ? 8'(pc >> (8 * (3 - k))) : st;
      chk(req, $sformatf("push %0d addr", k), t_addr[base+k], 32'h100 | 32'(8'(sp0 - 8'(k))));
      chk(req, $sformatf("push %0d we", k), 32'(t_we[base+k]), 32'd1);
      chk(req, $sformatf("push %0d data", k), 32'(t_dout[base+k]), 32'(e));
    end
  endtask

  task automatic chk_vec(input string req, input int base, input logic [31:0] va);
    for (int k = 0; k < 4; k++) begin
      chk(req, $sformatf("vector read %0d addr", k), t_addr[base+k], va + 32'(k));
      chk(req, $sformatf("vector read %0d we", k), 32'(t_we[base+k]), 32'd0);
    end
  endtask

  task automatic pulse_irq();
    irq = 1'b1; step(); irq = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    @(negedge clk); #1;
    chk("R1", "busy in reset", 32'(busy), 32'd0);
    chk("R1", "done in reset", 32'(done), 32'd0);
    chk("R1", "we in reset", 32'(we), 32'd0);
  endtask

  task automatic t_reset_seq();
    clear_trace();
    status_in = 8'h00; sp_in = 8'h33; pc_in = 32'h0;
    reset_req = 1'b1; step(); reset_req = 1'b0;
    wait_done();
    chk("R11", "trace length", 32'(t_n), 32'd5);
    chk_vec("R4", 0, 32'hFFFF_FFF8);
    chk("R5", "fetch addr after reset", t_addr[4], 32'h1234_5678);
    chk("R4", "assembled reset vector", d_pc, 32'h1234_5678);
    chk("R11", "sp unchanged", 32'(d_sp), 32'h33);
    chk("R11", "status sets idis", 32'(d_st), 32'h04);
    chk("R5", "done count", 32'(d_cnt), 32'd1);
  endtask

  task automatic t_brk();
    clear_trace();
    pc_in = 32'h203; status_in = 8'hA4; sp_in = 8'hFF;
    brk_req = 1'b1; step(); brk_req = 1'b0;
    wait_done();
    chk("R2", "trace length", 32'(t_n), 32'd10);
    chk_push("R3", 0, 8'hFF, 32'h205, 8'hB4);
    chk_vec("R4", 5, 32'hFFFF_FFFC);
    chk("R5", "fetch addr", t_addr[9], 32'h300);
    chk("R5", "pc_out", d_pc, 32'h300);
    chk("R5", "status_out", 32'(d_st), 32'hB4);
    chk("R2", "sp_out", 32'(d_sp), 32'hFA);
    chk("R5", "done count", 32'(d_cnt), 32'd1);
  endtask

  task automatic t_rti();
    clear_trace();
    sp_in = 8'hFA; status_in = 8'h00; pc_in = 32'h300;
    rti_req = 1'b1; step(); rti_req = 1'b0;
    wait_done();
    chk("R6", "trace length", 32'(t_n), 32'd7);
    for (int k = 0; k < 6; k++) begin
      chk("R6", $sformatf("pop %0d addr", k), t_addr[k], 32'h1FA + 32'(k));
      chk("R6", $sformatf("pop %0d we", k), 32'(t_we[k]), 32'd0);
    end
    chk("R6", "pc_out", d_pc, 32'h205);
    chk("R6", "status_out", 32'(d_st), 32'hB4);
    chk("R6", "sp_out", 32'(d_sp), 32'hFF);
    chk("R5", "fetch addr", t_addr[6], 32'h205);
  endtask

  task automatic t_irq();
    clear_trace();
    pc_in = 32'h1234_5678; status_in = 8'h80; sp_in = 8'h80;
    pulse_irq();
    wait_done();
    chk("R7", "trace length", 32'(t_n), 32'd10);
    chk_push("R3", 0, 8'h80, 32'h1234_5678, 8'hA0);
    chk_vec("R4", 5, 32'hFFFF_FFFC);
    chk("R5", "status_out", 32'(d_st), 32'hA4);
    chk("R2", "sp_out", 32'(d_sp), 32'h7B);
  endtask

  task automatic t_irq_masked();
    clear_trace();
    pc_in = 32'h400; status_in = 8'h04; sp_in = 8'hF0;
    pulse_irq();
    repeat (10) step();
    chk("R7", "masked irq not taken", 32'(t_n), 32'd0);
    status_in = 8'h00;
    wait_done();
    chk("R7", "pending irq taken after unmask", 32'(t_n), 32'd10);
    chk_push("R7", 0, 8'hF0, 32'h400, 8'h20);
  endtask

  task automatic t_irq_brk_same();
    clear_trace();
    pc_in = 32'h500; status_in = 8'h04; sp_in = 8'hE0;
    pulse_irq();
    step();
    chk("R7", "pending held while masked", 32'(t_n), 32'd0);
    status_in = 8'h00; brk_req = 1'b1; step(); brk_req = 1'b0;
    wait_done();
    repeat (6) step();
    chk("R8", "single sequence only", 32'(t_n), 32'd10);
    chk_push("R8", 0, 8'hE0, 32'h500, 8'h20);
  endtask

  task automatic t_stall();
    int wcnt;
    clear_trace();
    pc_in = 32'h600; status_in = 8'h00; sp_in = 8'hD0;
    brk_req = 1'b1; step(); brk_req = 1'b0;
    wait_trace(3);
    @(posedge clk); #1; rdy = 1'b0;
    repeat (3) @(posedge clk);
    #1; rdy = 1'b1;
    wait_done();
    wcnt = 0;
    for (int k = 0; k < t_n; k++) if (t_we[k]) wcnt++;
    chk("R10", "trace length with stall", 32'(t_n), 32'd13);
    chk("R10", "write count", 32'(wcnt), 32'd5);
    chk("R10", "stalled addr held", t_addr[4], t_addr[3]);
    chk("R10", "mem D0", 32'(stk[8'hD0]), 32'h00);
    chk("R10", "mem CE", 32'(stk[8'hCE]), 32'h06);
    chk("R10", "mem CD", 32'(stk[8'hCD]), 32'h02);
    chk("R10", "mem CC", 32'(stk[8'hCC]), 32'h30);
    chk("R10", "pc_out", d_pc, 32'h300);
  endtask

  task automatic t_abort();
    clear_trace();
    pc_in = 32'h700; status_in = 8'h04; sp_in = 8'hC0;
    pulse_irq();
    brk_req = 1'b1; step(); brk_req = 1'b0;
    wait_trace(3);
    @(posedge clk); #1; reset_req = 1'b1;
    step(); reset_req = 1'b0;
    wait_done();
    chk_vec("R9", t_n - 5, 32'hFFFF_FFF8);
    chk("R9", "pc_out reset vector", d_pc, 32'h1234_5678);
    chk("R11", "sp_out", 32'(d_sp), 32'hC0);
    chk("R5", "done count", 32'(d_cnt), 32'd1);
    clear_trace();
    status_in = 8'h00;
    repeat (10) step();
    chk("R9", "pending irq discarded", 32'(t_n), 32'd0);
  endtask

  task automatic t_wrap();
    clear_trace();
    pc_in = 32'h800; status_in = 8'h00; sp_in = 8'h01;
    brk_req = 1'b1; step(); brk_req = 1'b0;
    wait_done();
    chk_push("R2", 0, 8'h01, 32'h802, 8'h30);
    chk("R2", "sp_out wraps", 32'(d_sp), 32'hFC);
  endtask

  task automatic report();
    fin = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1600000;
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    vecmem[0] = 8'h00; vecmem[1]  = 8'h00; vecmem[2]  = 8'h00; vecmem[3]  = 8'h00;
    vecmem[4] = 8'h78; vecmem[5]  = 8'h56; vecmem[6]  = 8'h34; vecmem[7]  = 8'h12;
    vecmem[8] = 8'h00; vecmem[9]  = 8'h03; vecmem[10] = 8'h00; vecmem[11] = 8'h00;
    t_n = 0; d_cnt = 0; d_pc = '0; d_st = '0; d_sp = '0;
    rst_n = 1'b0; rdy = 1'b1; boundary = 1'b1; reset_req = 1'b0; irq = 1'b0;
    brk_req = 1'b0; rti_req = 1'b0; pc_in = '0; status_in = '0; sp_in = '0;
    t_reset_state();
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    step();
    t_reset_seq();
    t_brk();
    t_rti();
    t_irq();
    t_irq_masked();
    t_irq_brk_same();
    t_stall();
    t_abort();
    t_wrap();
    repeat (4) step();
    report();
  end

endmodule